// File: doc/BRIEF.md
# Error Signaling Controller for One Device Function

This block takes the errors that one function of a serial-link endpoint detects and decides what happens to each of them. It sets the detected bits of the device status and the advanced correctable and uncorrectable status bits. It asks a header-log stage to record the error, and it decides whether an error message goes upstream. When a message is sent, it carries a severity of correctable, non-fatal or fatal.

Each error arrives as a one-cycle strobe. The strobe carries a one-hot status vector, a flag that marks the error as correctable, a flag that marks it as possibly advisory, and a 16-bit source ID. The block reads its configuration as level inputs:
- whether the advanced reporting capability is present;
- the uncorrectable mask and severity vectors;
- the correctable mask vector;
- four reporting enables: correctable, non-fatal, fatal and unsupported request;
- the system-error enable.

A non-fatal error that may be advisory is reported as a correctable advisory error. When the log stage answers a log request with an overflow, the block raises a correctable header-log-overflow error of its own and runs it through the same path. The status bits are sticky until reset.

Top module: `err_signal_ctrl`

## Requirements
- R1: When `aer_present` is 0, an uncorrectable error is fatal if its bit is one of bits 0 to 5 and non-fatal otherwise. The bit meanings are: 0 link protocol, 1 surprise down, 2 receiver overflow, 3 flow-control protocol, 4 malformed packet, 5 internal, 6 poisoned, 7 end-to-end CRC, 8 unsupported request, 9 completion timeout, 10 completer abort, 11 unexpected completion. Without the capability no status vector changes and no log is requested.
- R2: When `aer_present` is 1, an uncorrectable error is fatal exactly when its bit is set in `unc_sev`. The default rule of R1 then plays no part.
- R3: A correctable error (`err_corr`=1, one bit among `err_bits[COR_W-1:0]`, with bit 5 = advisory non-fatal and bit 7 = header-log overflow) sets `dev_sts[0]`. With the capability present it also sets its bit in `cor_sts`. If that bit is set in `cor_mask`, no message is sent.
- R4: A correctable message (`msg_sev`=1) is sent only when `cor_rpt_en` is 1. A correctable-path error that comes from an unsupported request is also held back when `ur_rpt_en` is 0.
- R5: An uncorrectable error sets `dev_sts[2]` if fatal or `dev_sts[1]` if non-fatal. If its bit is set in `unc_mask`, its `unc_sts` bit is still set, but no log is requested and no message is sent.
- R6: An unmasked uncorrectable error sets its `unc_sts` bit and raises `log_req` with `log_bits` equal to the error bit. A message is sent with `msg_sev`=3 (fatal) or 2 (non-fatal) when `serr_en` is 1 or when the enable for that severity is 1.
- R7: An unsupported-request error (uncorrectable bit 8) sets `dev_sts[3]`. On the uncorrectable path its message is held back only when `ur_rpt_en` and `serr_en` are both 0.
- R8: A non-fatal error with `err_adv`=1 takes the correctable path as advisory non-fatal: it sets `dev_sts[0]` and `cor_sts[5]`. Unless bit 5 is masked, it also sets its `unc_sts` bit and requests a log only if its bit is clear in `unc_mask`. A fatal error ignores `err_adv`.
- R9: If `log_ovf` is 1 in a cycle where `log_req` is 1, the block raises a correctable header-log-overflow error two cycles later. That error sets `cor_sts[7]` and is sent as a correctable message with the source ID of the last external error.
- R10: A strobe whose status vector is zero, has more than one bit set, or (when correctable) has a bit at or above `COR_W` is ignored. No status changes, no log is requested and no message is sent.
- R11: `msg_valid` and `log_req` are registered one-cycle pulses that appear in the cycle after the strobe. `msg_src` carries the strobe's `err_src`. All status bits hold until reset, and reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | One-cycle strobe of a detected error |
| err_corr | input | 1 | 1 = correctable error |
| err_adv | input | 1 | Error may be advisory non-fatal |
| err_bits | input | UNC_W | One-hot error status |
| err_src | input | 16 | Source ID of the error |
| aer_present | input | 1 | Advanced reporting capability present |
| unc_mask | input | UNC_W | Uncorrectable mask |
| unc_sev | input | UNC_W | Uncorrectable severity (1 = fatal) |
| cor_mask | input | COR_W | Correctable mask |
| cor_rpt_en | input | 1 | Correctable reporting enable |
| nf_rpt_en | input | 1 | Non-fatal reporting enable |
| fatal_rpt_en | input | 1 | Fatal reporting enable |
| ur_rpt_en | input | 1 | Unsupported-request reporting enable |
| serr_en | input | 1 | System-error enable |
| log_ovf | input | 1 | Log stage overflow, valid with log_req |
| dev_sts | output | 4 | Detected bits: 0 corr, 1 non-fatal, 2 fatal, 3 UR |
| cor_sts | output | COR_W | Correctable status |
| unc_sts | output | UNC_W | Uncorrectable status |
| log_req | output | 1 | Header log request pulse |
| log_bits | output | UNC_W | Error bit to log |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | 1 corr, 2 non-fatal, 3 fatal |
| msg_src | output | 16 | Message source ID |

## Verification
The checker takes for granted that the configuration inputs change only between strobes. It also takes for granted that `log_ovf` is driven only while `log_req` is high, since the gating properties compare each message against the enables sampled on the strobe edge. The bench keeps to this by resetting the block and loading a new configuration before each table vector. It pulses `log_ovf` only in the cycle in which it sees a log request.

// File: rtl/err_signal_pkg.sv
package err_signal_pkg;

    // uncorrectable bit positions used by the severity rule and gating
    localparam int unsigned UB_INTERNAL = 5;
    localparam int unsigned UB_UNSUPP   = 8;
    localparam logic [31:0] DEF_FATAL_SET = 32'h0000_003F;

    // correctable bit positions raised by the block itself
    localparam int unsigned CB_ADVISORY = 5;
    localparam int unsigned CB_HLOG_OVF = 7;

    // device status detected bits
    localparam int unsigned DS_COR = 0;
    localparam int unsigned DS_NF  = 1;
    localparam int unsigned DS_FAT = 2;
    localparam int unsigned DS_UR  = 3;

    typedef enum logic [1:0] {
        SEV_NONE     = 2'd0,
        SEV_COR      = 2'd1,
        SEV_NONFATAL = 2'd2,
        SEV_FATAL    = 2'd3
    } sev_e;

endpackage

// File: rtl/err_classify.sv
module err_classify
    import err_signal_pkg::*;
#(
    parameter int unsigned UNC_W = 16,
    parameter int unsigned COR_W = 8
) (
    input  logic             corr,
    input  logic             adv,
    input  logic [UNC_W-1:0] bits,
    input  logic             aer_present,
    input  logic [UNC_W-1:0] unc_sev,
    output logic             ev_ok,
    output logic             use_cor,
    output logic             adv_path,
    output logic             fatal,
    output logic             is_ur,
    output logic [COR_W-1:0] cor_bit,
    output logic [UNC_W-1:0] unc_bit
);

    localparam logic [UNC_W-1:0] DEF_FATAL = DEF_FATAL_SET[UNC_W-1:0];

    logic one_hot;
    logic high_clear;

    always_comb begin
        one_hot    = (bits != '0) && ((bits & (bits - 1'b1)) == '0);
        high_clear = (bits[UNC_W-1:COR_W] == '0);
        ev_ok      = one_hot && (!corr || high_clear);

        if (aer_present) begin
            fatal = !corr && ((bits & unc_sev) != '0);
        end else begin
            fatal = !corr && ((bits & DEF_FATAL) != '0);
        end

        adv_path = !corr && adv && !fatal;
        use_cor  = corr || adv_path;
        is_ur    = !corr && bits[UB_UNSUPP];

        if (corr) begin
            cor_bit = bits[COR_W-1:0];
            unc_bit = '0;
        end else begin
            cor_bit = '0;
            if (adv_path) begin
                cor_bit[CB_ADVISORY] = 1'b1;
            end
            unc_bit = bits;
        end
    end

endmodule

// File: rtl/err_msg_gate.sv
module err_msg_gate
    import err_signal_pkg::*;
(
    input  logic  use_cor,
    input  logic  fatal,
    input  logic  is_ur,
    input  logic  blocked,
    input  logic  cor_rpt_en,
    input  logic  nf_rpt_en,
    input  logic  fatal_rpt_en,
    input  logic  ur_rpt_en,
    input  logic  serr_en,
    output logic  emit,
    output sev_e  sev
);

    logic ur_hold;

    always_comb begin
        if (use_cor) begin
            ur_hold = is_ur && !ur_rpt_en;
            emit    = !blocked && !ur_hold && cor_rpt_en;
            sev     = SEV_COR;
        end else begin
            ur_hold = is_ur && !ur_rpt_en && !serr_en;
            emit    = !blocked && !ur_hold &&
                      (serr_en || (fatal ? fatal_rpt_en : nf_rpt_en));
            sev     = fatal ? SEV_FATAL : SEV_NONFATAL;
        end
    end

endmodule

// File: rtl/err_signal_ctrl.sv
module err_signal_ctrl
    import err_signal_pkg::*;
#(
    parameter int unsigned UNC_W = 16,
    parameter int unsigned COR_W = 8,
    parameter int unsigned SRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_valid,
    input  logic             err_corr,
    input  logic             err_adv,
    input  logic [UNC_W-1:0] err_bits,
    input  logic [SRC_W-1:0] err_src,
    input  logic             aer_present,
    input  logic [UNC_W-1:0] unc_mask,
    input  logic [UNC_W-1:0] unc_sev,
    input  logic [COR_W-1:0] cor_mask,
    input  logic             cor_rpt_en,
    input  logic             nf_rpt_en,
    input  logic             fatal_rpt_en,
    input  logic             ur_rpt_en,
    input  logic             serr_en,
    input  logic             log_ovf,
    output logic [3:0]       dev_sts,
    output logic [COR_W-1:0] cor_sts,
    output logic [UNC_W-1:0] unc_sts,
    output logic             log_req,
    output logic [UNC_W-1:0] log_bits,
    output logic             msg_valid,
    output logic [1:0]       msg_sev,
    output logic [SRC_W-1:0] msg_src
);

    typedef struct packed {
        logic [3:0]       dev;
        logic [COR_W-1:0] cor;
        logic [UNC_W-1:0] unc;
        logic             log_v;
        logic [UNC_W-1:0] log_bits;
        logic             msg_v;
        sev_e             msg_sev;
        logic [SRC_W-1:0] msg_src;
        logic             hlo_pend;
        logic [SRC_W-1:0] last_src;
    } state_t;

    state_t st_d, st_q;

    // selected event: external strobe first, pending overflow otherwise
    logic             take_hlo;
    logic             sel_valid;
    logic             sel_corr;
    logic             sel_adv;
    logic [UNC_W-1:0] sel_bits;
    logic [SRC_W-1:0] sel_src;

    always_comb begin
        take_hlo  = st_q.hlo_pend && !err_valid;
        sel_valid = err_valid || take_hlo;
        sel_corr  = err_valid ? err_corr : 1'b1;
        sel_adv   = err_valid ? err_adv  : 1'b0;
        sel_src   = err_valid ? err_src  : st_q.last_src;
        if (err_valid) begin
            sel_bits = err_bits;
        end else begin
            sel_bits = '0;
            sel_bits[CB_HLOG_OVF] = 1'b1;
        end
    end

    logic             ev_ok, use_cor, adv_path, fatal, is_ur;
    logic [COR_W-1:0] cor_bit;
    logic [UNC_W-1:0] unc_bit;

    err_classify #(
        .UNC_W (UNC_W),
        .COR_W (COR_W)
    ) u_classify (
        .corr        (sel_corr),
        .adv         (sel_adv),
        .bits        (sel_bits),
        .aer_present (aer_present),
        .unc_sev     (unc_sev),
        .ev_ok       (ev_ok),
        .use_cor     (use_cor),
        .adv_path    (adv_path),
        .fatal       (fatal),
        .is_ur       (is_ur),
        .cor_bit     (cor_bit),
        .unc_bit     (unc_bit)
    );

    logic cor_masked;
    logic unc_masked;
    logic blocked;
    logic emit;
    sev_e sev;

    always_comb begin
        cor_masked = aer_present && ((cor_bit & cor_mask) != '0);
        unc_masked = aer_present && ((unc_bit & unc_mask) != '0);
        blocked    = use_cor ? cor_masked : unc_masked;
    end

    err_msg_gate u_gate (
        .use_cor      (use_cor),
        .fatal        (fatal),
        .is_ur        (is_ur),
        .blocked      (blocked),
        .cor_rpt_en   (cor_rpt_en),
        .nf_rpt_en    (nf_rpt_en),
        .fatal_rpt_en (fatal_rpt_en),
        .ur_rpt_en    (ur_rpt_en),
        .serr_en      (serr_en),
        .emit         (emit),
        .sev          (sev)
    );

    always_comb begin
        st_d          = st_q;
        st_d.log_v    = 1'b0;
        st_d.log_bits = '0;
        st_d.msg_v    = 1'b0;
        st_d.hlo_pend = (st_q.hlo_pend && !take_hlo) || (st_q.log_v && log_ovf);

        if (sel_valid && err_valid && ev_ok) begin
            st_d.last_src = err_src;
        end

        if (sel_valid && ev_ok) begin
            if (is_ur) begin
                st_d.dev[DS_UR] = 1'b1;
            end
            if (use_cor) begin
                st_d.dev[DS_COR] = 1'b1;
                if (aer_present) begin
                    st_d.cor = st_q.cor | cor_bit;
                    if (adv_path && !cor_masked) begin
                        st_d.unc = st_q.unc | unc_bit;
                        if (!unc_masked) begin
                            st_d.log_v    = 1'b1;
                            st_d.log_bits = unc_bit;
                        end
                    end
                end
            end else begin
                if (fatal) begin
                    st_d.dev[DS_FAT] = 1'b1;
                end else begin
                    st_d.dev[DS_NF] = 1'b1;
                end
                if (aer_present) begin
                    st_d.unc = st_q.unc | unc_bit;
                    if (!unc_masked) begin
                        st_d.log_v    = 1'b1;
                        st_d.log_bits = unc_bit;
                    end
                end
            end
            st_d.msg_v   = emit;
            st_d.msg_sev = emit ? sev : SEV_NONE;
            st_d.msg_src = sel_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_sts   = st_q.dev;
    assign cor_sts   = st_q.cor;
    assign unc_sts   = st_q.unc;
    assign log_req   = st_q.log_v;
    assign log_bits  = st_q.log_bits;
    assign msg_valid = st_q.msg_v;
    assign msg_sev   = st_q.msg_sev;
    assign msg_src   = st_q.msg_src;

endmodule

// File: rtl/err_signal_ctrl_chk.sv
module err_signal_ctrl_chk #(
    parameter int unsigned UNC_W = 16,
    parameter int unsigned COR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             aer_present,
    input logic             cor_rpt_en,
    input logic             fatal_rpt_en,
    input logic             nf_rpt_en,
    input logic             serr_en,
    input logic [3:0]       dev_sts,
    input logic [COR_W-1:0] cor_sts,
    input logic [UNC_W-1:0] unc_sts,
    input logic             log_req,
    input logic [UNC_W-1:0] log_bits,
    input logic             msg_valid,
    input logic [1:0]       msg_sev
);

    // R4: correctable message needs the correctable enable
    a_r4_cor_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_sev == 2'd1) |-> $past(cor_rpt_en));

    // R6: fatal message needs system-error or fatal enable
    a_r6_fatal_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_sev == 2'd3) |-> $past(serr_en || fatal_rpt_en));

    // R6: non-fatal message needs system-error or non-fatal enable
    a_r6_nf_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_sev == 2'd2) |-> $past(serr_en || nf_rpt_en));

    // R6: a log request names exactly one error bit
    a_r6_log_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |-> ($countones(log_bits) == 1));

    // R1: no log request without the capability
    a_r1_log_needs_cap: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |-> $past(aer_present));

    // R11: status bits are sticky
    a_r11_unc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((unc_sts & $past(unc_sts)) == $past(unc_sts)));

    a_r11_cor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cor_sts & $past(cor_sts)) == $past(cor_sts)));

    a_r11_dev_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dev_sts & $past(dev_sts)) == $past(dev_sts)));

    // R11: a message always carries a real severity
    a_r11_sev_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_sev != 2'd0));

endmodule

bind err_signal_ctrl err_signal_ctrl_chk #(
    .UNC_W (UNC_W),
    .COR_W (COR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .aer_present  (aer_present),
    .cor_rpt_en   (cor_rpt_en),
    .fatal_rpt_en (fatal_rpt_en),
    .nf_rpt_en    (nf_rpt_en),
    .serr_en      (serr_en),
    .dev_sts      (dev_sts),
    .cor_sts      (cor_sts),
    .unc_sts      (unc_sts),
    .log_req      (log_req),
    .log_bits     (log_bits),
    .msg_valid    (msg_valid),
    .msg_sev      (msg_sev)
);

// File: tb/err_signal_ctrl_test.sv
module err_signal_ctrl_test;

    localparam int UNC_W = 16;
    localparam int COR_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             err_valid = 1'b0, err_corr = 1'b0, err_adv = 1'b0;
    logic [UNC_W-1:0] err_bits = '0;
    logic [15:0]      err_src = '0;
    logic             aer_present = 1'b0;
    logic [UNC_W-1:0] unc_mask = '0, unc_sev = '0;
    logic [COR_W-1:0] cor_mask = '0;
    logic             cor_rpt_en = 1'b0, nf_rpt_en = 1'b0, fatal_rpt_en = 1'b0;
    logic             ur_rpt_en = 1'b0, serr_en = 1'b0, log_ovf = 1'b0;
    logic [3:0]       dev_sts;
    logic [COR_W-1:0] cor_sts;
    logic [UNC_W-1:0] unc_sts;
    logic             log_req, msg_valid;
    logic [UNC_W-1:0] log_bits;
    logic [1:0]       msg_sev;
    logic [15:0]      msg_src;

    always #10 clk = ~clk;

    err_signal_ctrl #(.UNC_W(UNC_W), .COR_W(COR_W), .SRC_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_corr(err_corr),
        .err_adv(err_adv), .err_bits(err_bits), .err_src(err_src),
        .aer_present(aer_present), .unc_mask(unc_mask), .unc_sev(unc_sev),
        .cor_mask(cor_mask), .cor_rpt_en(cor_rpt_en), .nf_rpt_en(nf_rpt_en),
        .fatal_rpt_en(fatal_rpt_en), .ur_rpt_en(ur_rpt_en), .serr_en(serr_en),
        .log_ovf(log_ovf), .dev_sts(dev_sts), .cor_sts(cor_sts),
        .unc_sts(unc_sts), .log_req(log_req), .log_bits(log_bits),
        .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // en = {serr, ur, fatal, nonfatal, cor}
    typedef struct packed {
        logic        corr;
        logic        adv;
        logic [15:0] bits;
        logic        aer;
        logic [15:0] umask;
        logic [15:0] usev;
        logic [7:0]  cmask;
        logic [4:0]  en;
        logic        x_msg;
        logic [1:0]  x_sev;
        logic        x_log;
        logic [3:0]  x_dev;
        logic [15:0] x_unc;
        logic [7:0]  x_cor;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TAB [NV] = '{
        // R3 correctable, reported
        '{1'b1,1'b0,16'h0002,1'b1,16'h0,16'h0,8'h00,5'b00001, 1'b1,2'd1,1'b0,4'h1,16'h0000,8'h02},
        // R3 correctable masked
        '{1'b1,1'b0,16'h0002,1'b1,16'h0,16'h0,8'h02,5'b00001, 1'b0,2'd0,1'b0,4'h1,16'h0000,8'h02},
        // R4 correctable, enable off
        '{1'b1,1'b0,16'h0002,1'b1,16'h0,16'h0,8'h00,5'b00000, 1'b0,2'd0,1'b0,4'h1,16'h0000,8'h02},
        // R1 malformed default fatal, no capability
        '{1'b0,1'b0,16'h0010,1'b0,16'h0,16'h0,8'h00,5'b00100, 1'b1,2'd3,1'b0,4'h4,16'h0000,8'h00},
        // R1 poisoned default non-fatal
        '{1'b0,1'b0,16'h0040,1'b0,16'h0,16'h0,8'h00,5'b00010, 1'b1,2'd2,1'b0,4'h2,16'h0000,8'h00},
        // R2 R6 severity register makes poisoned fatal, serr passes
        '{1'b0,1'b0,16'h0040,1'b1,16'h0,16'h0040,8'h00,5'b10000, 1'b1,2'd3,1'b1,4'h4,16'h0040,8'h00},
        // R5 masked uncorrectable
        '{1'b0,1'b0,16'h0040,1'b1,16'h0040,16'h0,8'h00,5'b11111, 1'b0,2'd0,1'b0,4'h2,16'h0040,8'h00},
        // R7 UR held back: ur enable and serr clear
        '{1'b0,1'b0,16'h0100,1'b1,16'h0,16'h0,8'h00,5'b00010, 1'b0,2'd0,1'b1,4'hA,16'h0100,8'h00},
        // R7 UR passed by serr
        '{1'b0,1'b0,16'h0100,1'b1,16'h0,16'h0,8'h00,5'b10000, 1'b1,2'd2,1'b1,4'hA,16'h0100,8'h00},
        // R8 advisory, logged
        '{1'b0,1'b1,16'h0200,1'b1,16'h0,16'h0,8'h00,5'b00001, 1'b1,2'd1,1'b1,4'h1,16'h0200,8'h20},
        // R8 advisory, uncorrectable bit masked: no log
        '{1'b0,1'b1,16'h0200,1'b1,16'h0200,16'h0,8'h00,5'b00001, 1'b1,2'd1,1'b0,4'h1,16'h0200,8'h20},
        // R8 advisory masked in correctable mask
        '{1'b0,1'b1,16'h0200,1'b1,16'h0,16'h0,8'h20,5'b00001, 1'b0,2'd0,1'b0,4'h1,16'h0000,8'h20},
        // R4 R8 advisory UR with ur enable clear
        '{1'b0,1'b1,16'h0100,1'b1,16'h0,16'h0,8'h00,5'b00001, 1'b0,2'd0,1'b1,4'h9,16'h0100,8'h20},
        // R8 fatal ignores advisory flag
        '{1'b0,1'b1,16'h0040,1'b1,16'h0,16'h0040,8'h00,5'b00100, 1'b1,2'd3,1'b1,4'h4,16'h0040,8'h00},
        // R10 two bits set
        '{1'b0,1'b0,16'h0042,1'b1,16'h0,16'h0,8'h00,5'b11111, 1'b0,2'd0,1'b0,4'h0,16'h0000,8'h00},
        // R10 correctable bit beyond width
        '{1'b1,1'b0,16'h0100,1'b1,16'h0,16'h0,8'h00,5'b11111, 1'b0,2'd0,1'b0,4'h0,16'h0000,8'h00},
        // R2 default-fatal bit made non-fatal by severity register
        '{1'b0,1'b0,16'h0010,1'b1,16'h0,16'h0,8'h00,5'b00010, 1'b1,2'd2,1'b1,4'h2,16'h0010,8'h00}
    };

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        err_valid = 1'b0;
        log_ovf = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R11 reset state
        do_reset();
        check("R11", "reset dev", {28'h0, dev_sts}, 32'h0);
        check("R11", "reset unc", {16'h0, unc_sts}, 32'h0);
        check("R11", "reset msg", {31'h0, msg_valid}, 32'h0);
        check("R11", "reset log", {31'h0, log_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            aer_present  = TAB[i].aer;
            unc_mask     = TAB[i].umask;
            unc_sev      = TAB[i].usev;
            cor_mask     = TAB[i].cmask;
            {serr_en, ur_rpt_en, fatal_rpt_en, nf_rpt_en, cor_rpt_en} = TAB[i].en;
            err_corr  = TAB[i].corr;
            err_adv   = TAB[i].adv;
            err_bits  = TAB[i].bits;
            err_src   = 16'hA000 + 16'(i);
            err_valid = 1'b1;
            @(negedge clk);
            err_valid = 1'b0;
            check($sformatf("R11 vec%0d", i), "msg_valid", {31'h0, msg_valid}, {31'h0, TAB[i].x_msg});
            if (TAB[i].x_msg) begin
                check($sformatf("R6 vec%0d", i), "msg_sev", {30'h0, msg_sev}, {30'h0, TAB[i].x_sev});
                check($sformatf("R11 vec%0d", i), "msg_src", {16'h0, msg_src}, {16'h0, err_src});
            end
            check($sformatf("R6 vec%0d", i), "log_req", {31'h0, log_req}, {31'h0, TAB[i].x_log});
            if (TAB[i].x_log)
                check($sformatf("R6 vec%0d", i), "log_bits", {16'h0, log_bits}, {16'h0, TAB[i].bits});
            check($sformatf("R5 vec%0d", i), "dev_sts", {28'h0, dev_sts}, {28'h0, TAB[i].x_dev});
            check($sformatf("R5 vec%0d", i), "unc_sts", {16'h0, unc_sts}, {16'h0, TAB[i].x_unc});
            check($sformatf("R3 vec%0d", i), "cor_sts", {24'h0, cor_sts}, {24'h0, TAB[i].x_cor});
            @(negedge clk);
            check($sformatf("R11 vec%0d", i), "pulse end", {31'h0, msg_valid}, 32'h0);
        end

        // R9 header-log overflow raised after a logged non-fatal error
        do_reset();
        aer_present = 1'b1; unc_mask = '0; unc_sev = '0; cor_mask = '0;
        {serr_en, ur_rpt_en, fatal_rpt_en, nf_rpt_en, cor_rpt_en} = 5'b00011;
        err_corr = 1'b0; err_adv = 1'b0; err_bits = 16'h0080; err_src = 16'h5A5A;
        err_valid = 1'b1;
        @(negedge clk);
        err_valid = 1'b0;
        check("R9", "first sev", {30'h0, msg_sev}, 32'd2);
        check("R9", "first log", {31'h0, log_req}, 32'h1);
        log_ovf = 1'b1;
        @(negedge clk);
        log_ovf = 1'b0;
        check("R9", "gap msg", {31'h0, msg_valid}, 32'h0);
        @(negedge clk);
        check("R9", "ovf msg", {31'h0, msg_valid}, 32'h1);
        check("R9", "ovf sev", {30'h0, msg_sev}, 32'd1);
        check("R9", "ovf src", {16'h0, msg_src}, 32'h5A5A);
        check("R9", "ovf cor_sts", {24'h0, cor_sts}, 32'h80);
        check("R9", "ovf dev", {28'h0, dev_sts}, 32'h3);
        @(negedge clk);
        check("R9", "single ovf", {31'h0, msg_valid}, 32'h0);

        // R11 status stays set after a later different error
        err_corr = 1'b1; err_bits = 16'h0001; err_src = 16'h0001; err_valid = 1'b1;
        @(negedge clk);
        err_valid = 1'b0;
        check("R11", "sticky unc", {16'h0, unc_sts}, 32'h0080);
        check("R11", "sticky cor", {24'h0, cor_sts}, 32'h81);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule